// File: doc/BRIEF.md
# Preset Power-Rail Enable Sequencer

This block turns on four power-rail enable outputs in a timed order once a synchronous start input goes high. Two outputs drive switching converters (rail A, rail B) and two drive linear regulators (linear 1, linear 2). A 3-bit profile code in a control register selects one of eight delay profiles. Each profile gives every rail its own turn-on delay, counted from the moment the start input rises.

Time is measured in half-millisecond units. A single-cycle tick input marks each unit. A per-rail enable register gates each output. When the start input drops, every output goes low at once and the elapsed count returns to zero. Software reaches both registers through a simple write/read port. Reads are combinational on the address.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, control register 0x07 reads 0x28 (profile code 3'b010 in bits 6:4, bit 3 set, all other bits zero), register 0x10 reads 0x75, and all four rail outputs are low.
- R2: In register 0x07, bits 6:4 (profile code) and bits 2:0 (mode bits) are read/write. Bit 7 always reads 0 and bit 3 always reads 1, whatever is written.
- R3: In register 0x10, bits 0, 2, 4 and 6 are the enable bits for rail A, rail B, linear 1 and linear 2. Writes to bits 1, 3, 5 and 7 have no effect, and those bits read 0, 0, 1 and 0.
- R4: A read of any address other than 0x07 or 0x10 returns 0x00.
- R5: The delays in ticks for (A, B, linear 1, linear 2) by code are: 000 (2,2,2,2), 001 (2,3,4,4), 010 (3,4,6,12), 011 (3,4,2,2), 100 (3,4,6,12), 101 (3,3,4,4), 110 (6,4,2,3), 111 (4,6,12,22). A rail output goes high on the clock edge that takes the N-th tick after the start input rises, where N is that rail's delay. The rail_on bit order is {linear 2, linear 1, B, A}.
- R6: A rail whose enable bit is 0 never goes high.
- R7: When the start input is low, all four outputs are low in that same cycle, and the elapsed count restarts from zero on the next assertion.
- R8: The profile code is captured on the cycle the start input rises. Writes to the code field during a sequence take effect only at the next assertion.
- R9: Clearing one rail's enable bit while that rail is on drops its output in the cycle after the write, and the other rails stay unchanged.
- R10: The elapsed count saturates instead of wrapping, so rails that are on stay on however many ticks follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| seq_start | input | 1 | Synchronous sequence start; low aborts |
| tick | input | 1 | Single-cycle half-millisecond time-base pulse |
| rail_on | output | 4 | Rail enables {linear 2, linear 1, B, A} |

## Verification
A wrong elapsed count or a wrong latched profile code shows at rail_on as an output that rises one or more ticks early or late. The bench therefore checks every output after every tick for all eight codes, so an error shows up within the tick where it occurs. A stuck rail flag shows up either when the start input drops, where the outputs must clear in the same cycle, or at the first tick after a restart. An enable-bit fault shows at rail_on one cycle after the register write.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int NRAIL  = 4;
  localparam int DLY_W  = 5;
  localparam int CODE_W = 3;

  typedef logic [DLY_W-1:0]  dly_t;
  typedef logic [CODE_W-1:0] code_t;

  // Turn-on delay in half-millisecond ticks for one rail under one profile.
  function automatic dly_t rail_delay(input code_t code, input logic [1:0] rail);
    dly_t a, b, l1, l2;
    case (code)
      3'd0: begin a = 5'd2; b = 5'd2; l1 = 5'd2;  l2 = 5'd2;  end
      3'd1: begin a = 5'd2; b = 5'd3; l1 = 5'd4;  l2 = 5'd4;  end
      3'd2: begin a = 5'd3; b = 5'd4; l1 = 5'd6;  l2 = 5'd12; end
      3'd3: begin a = 5'd3; b = 5'd4; l1 = 5'd2;  l2 = 5'd2;  end
      3'd4: begin a = 5'd3; b = 5'd4; l1 = 5'd6;  l2 = 5'd12; end
      3'd5: begin a = 5'd3; b = 5'd3; l1 = 5'd4;  l2 = 5'd4;  end
      3'd6: begin a = 5'd6; b = 5'd4; l1 = 5'd2;  l2 = 5'd3;  end
      default: begin a = 5'd4; b = 5'd6; l1 = 5'd12; l2 = 5'd22; end
    endcase
    case (rail)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return l1;
      default: return l2;
    endcase
  endfunction
endpackage

// File: rtl/rs_regs.sv
module rs_regs
  import rail_seq_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h07,
  parameter logic [7:0]  ENA_ADDR  = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output code_t             profile,
  output logic [NRAIL-1:0]  rail_en
);
  localparam code_t PROFILE_RST = 3'b010;

  logic [2:0] mode_q;
  code_t      profile_q;
  logic [NRAIL-1:0] en_q;

  wire hit_ctrl = wr && (addr == ADDR_W'(CTRL_ADDR));
  wire hit_ena  = wr && (addr == ADDR_W'(ENA_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      profile_q <= PROFILE_RST;
    end else if (hit_ctrl) begin
      mode_q    <= wdata[2:0];
      profile_q <= wdata[6:4];
    end
  end

  // Enable bits sit on the even data bits.
  for (genvar i = 0; i < NRAIL; i++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n)       en_q[i] <= 1'b1;
      else if (hit_ena) en_q[i] <= wdata[2*i];
    end
  end

  logic [DATA_W-1:0] ctrl_view, ena_view;
  always_comb begin
    ctrl_view      = '0;
    ctrl_view[2:0] = mode_q;
    ctrl_view[3]   = 1'b1;
    ctrl_view[6:4] = profile_q;
    ena_view       = '0;
    for (int i = 0; i < NRAIL; i++) ena_view[2*i] = en_q[i];
    ena_view[5]    = 1'b1;
  end

  always_comb begin
    if (addr == ADDR_W'(CTRL_ADDR))     rdata = ctrl_view;
    else if (addr == ADDR_W'(ENA_ADDR)) rdata = ena_view;
    else                                rdata = '0;
  end

  assign profile = profile_q;
  assign rail_en = en_q;

  // R2: the profile field follows a control write on the next cycle.
  assert_profile_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |=> profile == $past(wdata[6:4]));
  // R3: a write elsewhere leaves the enable bits untouched.
  assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ena |=> $stable(rail_en));
endmodule

// File: rtl/rs_timer.sv
module rs_timer
  import rail_seq_pkg::*;
#(
  parameter int CNT_W = DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  code_t            profile,
  output code_t            code_eff,
  output logic             step,
  output logic [CNT_W-1:0] cnt_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             start_q;
  code_t            code_q;
  logic [CNT_W-1:0] cnt_q;

  wire rise = start && !start_q;
  assign step     = start && tick;
  assign code_eff = rise ? profile : code_q;
  assign cnt_next = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      code_q  <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= start;
      if (rise) code_q <= profile;
      if (!start)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_next;
    end
  end

  // R7: idle clears the elapsed count.
  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> cnt_q == '0);
  // R8: the captured code holds while a sequence runs.
  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_q) |=> $stable(code_q));
  // R10: the count never wraps.
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && start) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/rs_rails.sv
module rs_rails
  import rail_seq_pkg::*;
#(
  parameter int CNT_W = DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_next,
  input  code_t            code_eff,
  input  logic [NRAIL-1:0] rail_en,
  output logic [NRAIL-1:0] rail_on
);
  logic [NRAIL-1:0] rail_q;
  logic [NRAIL-1:0] due_hit;

  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    wire dly_t dly = rail_delay(code_eff, 2'(i));
    assign due_hit[i] = step && (CNT_W'(dly) <= cnt_next);

    always_ff @(posedge clk) begin
      if (!rst_n || !start || !rail_en[i]) rail_q[i] <= 1'b0;
      else if (due_hit[i])                 rail_q[i] <= 1'b1;
    end

    assign rail_on[i] = rail_q[i] && start && rail_en[i];

    // R5: a rail flag rises only on a tick that reached its delay.
    assert_rise_on_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_q[i]) |-> $past(due_hit[i]));
    // R6: a set flag always had its enable bit on the cycle before.
    assert_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rail_q[i] |-> $past(rail_en[i]));
  end
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
  import rail_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = DLY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              seq_start,
  input  logic              tick,
  output logic [NRAIL-1:0]  rail_on
);
  code_t            profile, code_eff;
  logic [NRAIL-1:0] rail_en;
  logic             step;
  logic [CNT_W-1:0] cnt_next;

  rs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .profile(profile), .rail_en(rail_en)
  );

  rs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .tick(tick),
    .profile(profile), .code_eff(code_eff), .step(step), .cnt_next(cnt_next)
  );

  rs_rails #(.CNT_W(CNT_W)) u_rails (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .step(step),
    .cnt_next(cnt_next), .code_eff(code_eff), .rail_en(rail_en), .rail_on(rail_on)
  );

  // R7: no rail is on while the start input is low.
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_start |-> rail_on == '0);
endmodule

// File: tb/sim_rail_seq_top.sv
module sim_rail_seq_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, seq_start = 0, tick = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [3:0] rail_on;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rail_seq_top u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_start(seq_start),
    .tick(tick), .rail_on(rail_on));

  // Profile, then delays in tenths of a millisecond for A, B, linear 1, linear 2.
  localparam logic [30:0] VEC [8] = '{
    {3'd0, 7'd10, 7'd10, 7'd10, 7'd10},
    {3'd1, 7'd10, 7'd15, 7'd20, 7'd20},
    {3'd2, 7'd15, 7'd20, 7'd30, 7'd60},
    {3'd3, 7'd15, 7'd20, 7'd10, 7'd10},
    {3'd4, 7'd15, 7'd20, 7'd30, 7'd60},
    {3'd5, 7'd15, 7'd15, 7'd20, 7'd20},
    {3'd6, 7'd30, 7'd20, 7'd10, 7'd15},
    {3'd7, 7'd20, 7'd30, 7'd60, 7'd110}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); reg_addr = a; #1; check(req, reg_rdata, exp);
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; #1;
  endtask

  task automatic start_seq;
    @(negedge clk); seq_start = 1;
    @(negedge clk);
  endtask

  task automatic stop_seq(input string req);
    @(negedge clk); seq_start = 0; #1;
    check(req, {4'h0, rail_on}, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", 8'h07, 8'h28);
    rd("R1", 8'h10, 8'h75);
    check("R1", {4'h0, rail_on}, 8'h00);
    // R4 other addresses
    rd("R4", 8'h00, 8'h00);
    rd("R4", 8'h11, 8'h00);
    rd("R4", 8'hFF, 8'h00);
    // R2 control field access
    wr(8'h07, 8'hFF); rd("R2", 8'h07, 8'h7F);
    wr(8'h07, 8'h00); rd("R2", 8'h07, 8'h08);
    wr(8'h07, 8'h35); rd("R2", 8'h07, 8'h3D);
    // R3 enable register reserved bits
    wr(8'h10, 8'hFF); rd("R3", 8'h10, 8'h75);
    wr(8'h10, 8'h00); rd("R3", 8'h10, 8'h20);
    wr(8'h10, 8'hAA); rd("R3", 8'h10, 8'h20);
    wr(8'h10, 8'h55); rd("R3", 8'h10, 8'h75);

    // R5 table walk
    foreach (VEC[v]) begin
      logic [3:0] exp;
      wr(8'h07, {1'b0, VEC[v][30:28], 4'h0});
      start_seq();
      check("R5 pre-tick", {4'h0, rail_on}, 8'h00);
      for (int t = 1; t <= 24; t++) begin
        pulse();
        exp[0] = (VEC[v][27:21] / 5) <= t;
        exp[1] = (VEC[v][20:14] / 5) <= t;
        exp[2] = (VEC[v][13:7]  / 5) <= t;
        exp[3] = (VEC[v][6:0]   / 5) <= t;
        check($sformatf("R5 code %0d tick %0d", v, t), {4'h0, rail_on}, {4'h0, exp});
      end
      stop_seq("R7");
    end

    // R6 disabled rail B stays low
    wr(8'h10, 8'h71);
    wr(8'h07, 8'h00);
    start_seq();
    repeat (3) pulse();
    check("R6", {4'h0, rail_on}, 8'h0D);
    stop_seq("R7");
    wr(8'h10, 8'h75);

    // R8 profile write mid-sequence ignored until restart
    wr(8'h07, 8'h00);
    start_seq();
    pulse();
    wr(8'h07, 8'h70);
    pulse();
    check("R8 old code kept", {4'h0, rail_on}, 8'h0F);
    stop_seq("R7");
    start_seq();
    repeat (3) pulse();
    check("R8 new code used", {4'h0, rail_on}, 8'h00);
    pulse();
    check("R8 new code rail A", {4'h0, rail_on}, 8'h01);
    stop_seq("R7");

    // R7 restart from zero count
    wr(8'h07, 8'h00);
    start_seq();
    pulse();
    check("R7 count restarted", {4'h0, rail_on}, 8'h00);
    pulse();
    check("R7 after restart", {4'h0, rail_on}, 8'h0F);

    // R9 clear rail A enable while on
    @(negedge clk); reg_wr = 1; reg_addr = 8'h10; reg_wdata = 8'h74;
    #1; check("R9 before edge", {4'h0, rail_on}, 8'h0F);
    @(negedge clk); reg_wr = 0; #1;
    check("R9 after edge", {4'h0, rail_on}, 8'h0E);
    pulse();
    check("R9 others hold", {4'h0, rail_on}, 8'h0E);
    stop_seq("R7");
    wr(8'h10, 8'h75);

    // R10 saturation
    wr(8'h07, 8'h70);
    start_seq();
    for (int t = 1; t <= 40; t++) begin
      pulse();
      if (t >= 22) check($sformatf("R10 tick %0d", t), {4'h0, rail_on}, 8'h0F);
    end
    stop_seq("R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule